// File: doc/BRIEF.md
# Sampling Delay Sweep Tuner

This block chooses the receive sampling delay of a high-speed card interface. It sweeps a delay-line setting upward, one tap per trial, from a start tap to a maximum tap. Each trial follows the same steps. The block asks the receive FIFO to flush and waits for the flush to finish. It then requests a tuning transfer from an external command engine and takes back a verdict. The verdict is a pass only when the returned data pattern matched the expected pattern bit for bit.

Across the sweep the block keeps every contiguous run of passing taps and remembers the widest one. When the sweep ends it takes the midpoint of that run and subtracts the margin the auto-tuning logic needs. The result goes out as the final delay, together with a one-cycle completion strobe. A sweep with no passing tap raises an error and leaves the delay untouched.

Top module: `tap_sweep_tuner`

## Requirements
- R1: After reset, `busy`, `done`, `tuned_ok`, `tune_err`, `fifo_rst_req`, `trial_start` and `tune_rst` are 0 and `final_delay` is 0.
- R2: Each run begins with exactly one single-cycle `tune_rst` pulse, whatever earlier runs left behind.
- R3: A run tries each tap once, in ascending order, from `start_tap` to `max_tap` inclusive. Each trial is one `trial_start` pulse, and `trial_tap` carries that trial's tap and holds until the verdict arrives.
- R4: Before every trial `fifo_rst_req` rises and stays high until `fifo_rst_done` is seen. `trial_start` follows only after the request has cleared, so there is exactly one flush per trial.
- R5: A trial passes only when `trial_match` is 1 in the cycle `trial_done` is 1. A single failing tap splits two passing runs.
- R6: The widest contiguous run of passing taps is chosen. On equal widths, the run at lower taps wins.
- R7: `final_delay` = floor((first + last) / 2) − AUTO_WIN of the chosen run, clamped at 0 (AUTO_WIN defaults to 3).
- R8: A sweep where every tap passes succeeds and treats the whole range as one run.
- R9: A sweep with no passing tap ends with `tune_err`=1 and `tuned_ok`=0, and leaves `final_delay` unchanged. `tuned_ok` and `tune_err` are never both 1.
- R10: `done` is a single-cycle strobe that marks valid results, and `busy` is 0 while it is high. `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning run (sampled when idle) |
| start_tap | input | TAP_W | First tap of the sweep |
| max_tap | input | TAP_W | Last tap of the sweep |
| fifo_rst_done | input | 1 | FIFO flush finished |
| trial_done | input | 1 | Tuning transfer finished, verdict valid |
| trial_match | input | 1 | Returned pattern matched exactly |
| tune_rst | output | 1 | One-cycle reset of the tuning circuit |
| fifo_rst_req | output | 1 | FIFO flush request, held until done |
| trial_start | output | 1 | One-cycle request for a tuning transfer |
| trial_tap | output | TAP_W | Delay tap under trial |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| tuned_ok | output | 1 | Last run found a passing run |
| tune_err | output | 1 | Last run found no passing tap |
| final_delay | output | TAP_W | Selected sampling delay |

## Verification
After `start` is sampled, `busy` and `tune_rst` are due one clock later, and `fifo_rst_req` follows one clock after that. Each flush acknowledgement puts `trial_start` one clock after it. A verdict on the last tap raises `done` two clocks later, and `final_delay`, `tuned_ok` and `tune_err` are valid in that same cycle. The bench drives every input at the falling edge and samples every output at the next falling edge, so each check reads the value that the preceding rising edge registered. Results are read exactly in the cycle `done` is high, and `done` is checked low again one cycle later.

// File: rtl/tune_pkg.sv
package tune_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_FLUSH,
      ST_TRIAL,
      ST_WAIT,
      ST_FINISH
   } tune_st_e;
endpackage

// File: rtl/tune_seq_ctrl.sv
module tune_seq_ctrl
   import tune_pkg::*;
#(
   parameter int TAP_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TAP_W-1:0] start_tap,
   input  logic [TAP_W-1:0] max_tap,
   input  logic             fifo_rst_done,
   input  logic             trial_done,
   output tune_st_e         state,
   output logic [TAP_W-1:0] cur_tap,
   output logic             rec,
   output logic             clear
);
   logic [TAP_W-1:0] last_q;

   assign rec   = (state == ST_WAIT) && trial_done;
   assign clear = (state == ST_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur_tap <= '0;
         last_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               cur_tap <= start_tap;
               last_q  <= max_tap;
               state   <= ST_RST;
            end
            ST_RST:    state <= ST_FLUSH;
            ST_FLUSH:  if (fifo_rst_done) state <= ST_TRIAL;
            ST_TRIAL:  state <= ST_WAIT;
            ST_WAIT: if (trial_done) begin
               if (cur_tap >= last_q) begin
                  state <= ST_FINISH;
               end else begin
                  cur_tap <= cur_tap + 1'b1;
                  state   <= ST_FLUSH;
               end
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tune_window_track.sv
module tune_window_track #(
   parameter int TAP_W = 7,
   localparam int LEN_W = TAP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             rec,
   input  logic             pass,
   input  logic [TAP_W-1:0] tap,
   output logic [TAP_W-1:0] best_start,
   output logic [LEN_W-1:0] best_len
);
   logic [TAP_W-1:0] run_start;
   logic [LEN_W-1:0] run_len;
   logic [LEN_W-1:0] next_len;
   logic [TAP_W-1:0] next_start;

   assign next_len   = run_len + 1'b1;
   assign next_start = (run_len == '0) ? tap : run_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_start  <= '0;
         run_len    <= '0;
         best_start <= '0;
         best_len   <= '0;
      end else if (clear) begin
         run_start  <= '0;
         run_len    <= '0;
         best_start <= '0;
         best_len   <= '0;
      end else if (rec) begin
         if (pass) begin
            run_start <= next_start;
            run_len   <= next_len;
            // strict compare: an equal-width later run never displaces the earlier one
            if (next_len > best_len) begin
               best_len   <= next_len;
               best_start <= next_start;
            end
         end else begin
            run_len <= '0;
         end
      end
   end
endmodule

// File: rtl/tune_pick.sv
module tune_pick #(
   parameter int TAP_W    = 7,
   parameter int AUTO_WIN = 3,
   localparam int LEN_W   = TAP_W + 1
) (
   input  logic [TAP_W-1:0] best_start,
   input  logic [LEN_W-1:0] best_len,
   output logic             found,
   output logic [TAP_W-1:0] delay
);
   logic [LEN_W-1:0] mid;
   logic [LEN_W-1:0] half;

   assign found = (best_len != '0);
   assign half  = found ? ((best_len - 1'b1) >> 1) : '0;
   assign mid   = {1'b0, best_start} + half;

   generate
      if (AUTO_WIN == 0) begin : g_no_margin
         assign delay = mid[TAP_W-1:0];
      end else begin : g_margin
         localparam logic [LEN_W-1:0] MARGIN = LEN_W'(AUTO_WIN);
         logic [LEN_W-1:0] trimmed;
         assign trimmed = (mid >= MARGIN) ? (mid - MARGIN) : '0;
         assign delay   = trimmed[TAP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/tap_sweep_tuner.sv
module tap_sweep_tuner
   import tune_pkg::*;
#(
   parameter int TAP_W    = 7,
   parameter int AUTO_WIN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TAP_W-1:0] start_tap,
   input  logic [TAP_W-1:0] max_tap,
   input  logic             fifo_rst_done,
   input  logic             trial_done,
   input  logic             trial_match,
   output logic             tune_rst,
   output logic             fifo_rst_req,
   output logic             trial_start,
   output logic [TAP_W-1:0] trial_tap,
   output logic             busy,
   output logic             done,
   output logic             tuned_ok,
   output logic             tune_err,
   output logic [TAP_W-1:0] final_delay
);
   localparam int LEN_W = TAP_W + 1;

   generate
      if (TAP_W < 2 || TAP_W > 12) begin : g_bad_width
         $error("tap_sweep_tuner: TAP_W out of range");
      end
      if (AUTO_WIN < 0 || AUTO_WIN >= (1 << TAP_W)) begin : g_bad_margin
         $error("tap_sweep_tuner: AUTO_WIN out of range");
      end
   endgenerate

   tune_st_e         state;
   logic [TAP_W-1:0] cur_tap;
   logic             rec;
   logic             clear;
   logic [TAP_W-1:0] best_start;
   logic [LEN_W-1:0] best_len;
   logic             found;
   logic [TAP_W-1:0] pick_delay;

   tune_seq_ctrl #(.TAP_W(TAP_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .start_tap     (start_tap),
      .max_tap       (max_tap),
      .fifo_rst_done (fifo_rst_done),
      .trial_done    (trial_done),
      .state         (state),
      .cur_tap       (cur_tap),
      .rec           (rec),
      .clear         (clear)
   );

   tune_window_track #(.TAP_W(TAP_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .rec        (rec),
      .pass       (trial_match),
      .tap        (cur_tap),
      .best_start (best_start),
      .best_len   (best_len)
   );

   tune_pick #(.TAP_W(TAP_W), .AUTO_WIN(AUTO_WIN)) u_pick (
      .best_start (best_start),
      .best_len   (best_len),
      .found      (found),
      .delay      (pick_delay)
   );

   assign tune_rst     = (state == ST_RST);
   assign fifo_rst_req = (state == ST_FLUSH);
   assign trial_start  = (state == ST_TRIAL);
   assign trial_tap    = cur_tap;
   assign busy         = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done        <= 1'b0;
         tuned_ok    <= 1'b0;
         tune_err    <= 1'b0;
         final_delay <= '0;
      end else begin
         done <= (state == ST_FINISH);
         if (state == ST_RST) begin
            tuned_ok <= 1'b0;
            tune_err <= 1'b0;
         end else if (state == ST_FINISH) begin
            tuned_ok <= found;
            tune_err <= !found;
            if (found) final_delay <= pick_delay;
         end
      end
   end
endmodule

// File: rtl/tap_sweep_tuner_chk.sv
module tap_sweep_tuner_chk #(
   parameter int TAP_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_rst_done,
   input logic             tune_rst,
   input logic             fifo_rst_req,
   input logic             trial_start,
   input logic [TAP_W-1:0] trial_tap,
   input logic             busy,
   input logic             done,
   input logic             tuned_ok,
   input logic             tune_err,
   input logic [TAP_W-1:0] final_delay
);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
   // R4
   trial_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trial_start |-> ($past(fifo_rst_req) && $past(fifo_rst_done)));
   // R4
   flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rst_req && !fifo_rst_done) |=> fifo_rst_req);
   // R2
   tune_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tune_rst |=> (!tune_rst && fifo_rst_req));
   // R3
   tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trial_start |=> $stable(trial_tap));
   // R9
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tune_err) |-> $stable(final_delay));
   // R9
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tuned_ok && tune_err));
endmodule

bind tap_sweep_tuner tap_sweep_tuner_chk #(.TAP_W(TAP_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fifo_rst_done (fifo_rst_done),
   .tune_rst      (tune_rst),
   .fifo_rst_req  (fifo_rst_req),
   .trial_start   (trial_start),
   .trial_tap     (trial_tap),
   .busy          (busy),
   .done          (done),
   .tuned_ok      (tuned_ok),
   .tune_err      (tune_err),
   .final_delay   (final_delay)
);

// File: tb/tap_sweep_tuner_bench.sv
module tap_sweep_tuner_bench;
   localparam int TAP_W = 7;

   typedef struct packed {
      logic [7:0] lo1;
      logic [7:0] hi1;
      logic [7:0] lo2;
      logic [7:0] hi2;
      logic [7:0] st;
      logic [7:0] mx;
      logic       ok;
      logic [7:0] dly;
      logic       inject;
   } vec_t;

   // passing taps are lo1..hi1 and lo2..hi2; an empty run has lo > hi
   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{8'd0,  8'd31, 8'd1,  8'd0,  8'd0, 8'd31, 1'b1, 8'd12, 1'b0}, // R8 all pass
      '{8'd4,  8'd9,  8'd12, 8'd25, 8'd0, 8'd31, 1'b1, 8'd15, 1'b1}, // R6 wider second run, extra start
      '{8'd2,  8'd10, 8'd12, 8'd16, 8'd0, 8'd31, 1'b1, 8'd3,  1'b0}, // R5 one-tap gap
      '{8'd3,  8'd6,  8'd10, 8'd13, 8'd0, 8'd31, 1'b1, 8'd1,  1'b0}, // R6 tie, lower wins
      '{8'd0,  8'd3,  8'd1,  8'd0,  8'd0, 8'd31, 1'b1, 8'd0,  1'b0}, // R7 clamp at zero
      '{8'd0,  8'd13, 8'd15, 8'd31, 8'd8, 8'd20, 1'b1, 8'd7,  1'b0}, // R3 offset range
      '{8'd0,  8'd5,  8'd20, 8'd31, 8'd0, 8'd31, 1'b1, 8'd22, 1'b0}  // R6 run ends at max
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [TAP_W-1:0] start_tap = '0;
   logic [TAP_W-1:0] max_tap = '0;
   logic             fifo_rst_done = 1'b0;
   logic             trial_done = 1'b0;
   logic             trial_match = 1'b0;
   logic             tune_rst;
   logic             fifo_rst_req;
   logic             trial_start;
   logic [TAP_W-1:0] trial_tap;
   logic             busy;
   logic             done;
   logic             tuned_ok;
   logic             tune_err;
   logic [TAP_W-1:0] final_delay;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tap_sweep_tuner #(.TAP_W(TAP_W), .AUTO_WIN(3)) u_tap_sweep_tuner (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .start_tap     (start_tap),
      .max_tap       (max_tap),
      .fifo_rst_done (fifo_rst_done),
      .trial_done    (trial_done),
      .trial_match   (trial_match),
      .tune_rst      (tune_rst),
      .fifo_rst_req  (fifo_rst_req),
      .trial_start   (trial_start),
      .trial_tap     (trial_tap),
      .busy          (busy),
      .done          (done),
      .tuned_ok      (tuned_ok),
      .tune_err      (tune_err),
      .final_delay   (final_delay)
   );

   task automatic check(input bit cond, input string req, input int act, input int exp);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      while (cyc < 150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
   end

   // one full run against a responder model; results sampled in the done cycle
   task automatic run_case(input int lo1, input int hi1, input int lo2, input int hi2,
                           input int st, input int mx, input bit inject,
                           output bit g_ok, output bit g_err, output int g_dly,
                           output int trials, output int rsts, output int flushes,
                           output bit order_ok, output bit busy_ok);
      logic [127:0] map;
      int  exp_tap;
      int  req_age;
      int  pend;
      int  pend_tap;
      int  iter;
      bit  seen_done;
      for (int t = 0; t < 128; t++)
         map[t] = ((t >= lo1) && (t <= hi1)) || ((t >= lo2) && (t <= hi2));
      trials = 0; rsts = 0; flushes = 0; order_ok = 1'b1; busy_ok = 1'b1;
      exp_tap = st; req_age = 0; pend = 0; pend_tap = 0; seen_done = 1'b0;
      g_ok = 1'b0; g_err = 1'b0; g_dly = 0;
      @(negedge clk);
      start_tap = TAP_W'(st);
      max_tap   = TAP_W'(mx);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!busy) busy_ok = 1'b0;
      if (tune_rst) rsts++;
      iter = 0;
      while (!seen_done && iter < 20000) begin
         @(negedge clk);
         iter++;
         fifo_rst_done = 1'b0;
         trial_done    = 1'b0;
         trial_match   = 1'b0;
         start         = 1'b0;
         if (done) begin
            seen_done = 1'b1;
            g_ok  = tuned_ok;
            g_err = tune_err;
            g_dly = int'(final_delay);
            if (busy) busy_ok = 1'b0;
         end else begin
            if (!busy) busy_ok = 1'b0;
            if (inject && iter == 12) start = 1'b1;
            if (tune_rst) rsts++;
            if (fifo_rst_req) begin
               req_age++;
               if (req_age == 2) begin
                  fifo_rst_done = 1'b1;
                  flushes++;
                  req_age = 0;
               end
            end
            if (trial_start) begin
               if (int'(trial_tap) != exp_tap || flushes != trials + 1) order_ok = 1'b0;
               trials++;
               exp_tap++;
               pend = 3;
               pend_tap = int'(trial_tap);
            end else if (pend > 0) begin
               if (int'(trial_tap) != pend_tap) order_ok = 1'b0;
               pend--;
               if (pend == 0) begin
                  trial_done  = 1'b1;
                  trial_match = map[pend_tap];
               end
            end
         end
      end
      @(negedge clk);
      check(!done, "R10 done single cycle", int'(done), 0);
   endtask

   initial begin
      bit g_ok, g_err, order_ok, busy_ok;
      int g_dly, trials, rsts, flushes, held;
      #1;
      repeat (3) @(negedge clk);
      // R1 reset values
      check(!busy && !done && !fifo_rst_req && !trial_start && !tune_rst, "R1 control idle",
            int'({busy, done, fifo_rst_req, trial_start, tune_rst}), 0);
      check(!tuned_ok && !tune_err && final_delay == '0, "R1 result regs",
            int'({tuned_ok, tune_err, final_delay}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy, "R1 idle after release", int'(busy), 0);

      for (int v = 0; v < NV; v++) begin
         run_case(int'(VECS[v].lo1), int'(VECS[v].hi1), int'(VECS[v].lo2), int'(VECS[v].hi2),
                  int'(VECS[v].st), int'(VECS[v].mx), VECS[v].inject,
                  g_ok, g_err, g_dly, trials, rsts, flushes, order_ok, busy_ok);
         check(g_ok == VECS[v].ok && !g_err, "R6 R8 success flags", int'({g_ok, g_err}), 2);
         check(g_dly == int'(VECS[v].dly), "R7 final delay", g_dly, int'(VECS[v].dly));
         check(trials == int'(VECS[v].mx) - int'(VECS[v].st) + 1, "R3 trial count",
               trials, int'(VECS[v].mx) - int'(VECS[v].st) + 1);
         check(order_ok, "R3 tap order and hold", int'(order_ok), 1);
         check(rsts == 1, "R2 one reset pulse per run", rsts, 1);
         check(flushes == trials, "R4 one flush per trial", flushes, trials);
         check(busy_ok, "R10 busy window", int'(busy_ok), 1);
      end

      // R9: no passing tap keeps the previous delay (22) and flags an error
      run_case(1, 0, 1, 0, 0, 15, 1'b0, g_ok, g_err, g_dly, trials, rsts, flushes, order_ok, busy_ok);
      check(g_err && !g_ok, "R9 error flags", int'({g_ok, g_err}), 1);
      check(g_dly == 22, "R9 delay unchanged", g_dly, 22);
      check(trials == 16, "R3 trial count no-pass run", trials, 16);

      // R5: a single passing tap between failures is a run of width one
      run_case(40, 40, 1, 0, 30, 50, 1'b0, g_ok, g_err, g_dly, trials, rsts, flushes, order_ok, busy_ok);
      check(g_ok && g_dly == 37, "R5 single-tap run", g_dly, 37);

      // R4: flush request holds while no acknowledgement arrives
      @(negedge clk);
      start_tap = '0; max_tap = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      held = 0;
      for (int k = 0; k < 5; k++) begin
         if (fifo_rst_req && !trial_start) held++;
         @(negedge clk);
      end
      check(held == 5, "R4 request held without ack", held, 5);
      fifo_rst_done = 1'b1;
      @(negedge clk);
      fifo_rst_done = 1'b0;
      check(trial_start && !fifo_rst_req, "R4 trial after ack",
            int'({trial_start, fifo_rst_req}), 2);
      repeat (2) @(negedge clk);
      trial_done = 1'b1; trial_match = 1'b1;
      @(negedge clk);
      trial_done = 1'b0; trial_match = 1'b0;
      @(negedge clk);
      check(done && tuned_ok && final_delay == '0, "R7 R8 single tap run",
            int'({done, tuned_ok, final_delay}), 384);

      finish_run();
   end
endmodule